// File: doc/BRIEF.md
# Idle-Aware Link Channel Controller

This block is the digital supervisor of one unidirectional single-bit serial channel. It oversamples the incoming line with a fast local clock. It measures the time since the last transition and from that decides whether the line carries live data or has gone quiet. A small state machine runs through calibration, locked pass-through and idle. The channel output follows the input only while the channel is locked. In every other state the output is driven to logic high.

Calibration runs out of reset. It runs again each time qualified activity follows an idle period, and again when the sending side's supply comes back. A quiet period that ends before a minimum length raises a one-cycle violation pulse. A separate enable input, passed through a synchronizer, qualifies the output as driven or high impedance. All time limits are parameters counted in sampling-clock cycles.

Top module: `link_chan_ctrl`

## Requirements
- R1: While `rst_n` is low, `chan_state` reads 1 (calibrating), `tx_bit` is 1 and `tx_bit_oe` is 0. Calibration is the first state after reset.
- R2: Whenever `chan_state` is not 2 (locked), `tx_bit` is 1 from the next cycle on, whatever `rx_bit` does.
- R3: While transitions keep arriving, the channel stays in state 1 for `CAL_CYC` cycles and then enters state 2.
- R4: In state 2, `tx_bit` equals `rx_bit` delayed by three clock cycles: two synchronizer stages plus one output register.
- R5: If `rx_bit` shows no transition for `IDLE_TO_CYC` cycles while in state 1 or 2, the channel enters state 3 (idle) and `tx_bit` is held at 1. This applies whether the line rests high or low.
- R6: From state 3 the channel goes to state 1 only after two transitions at most `ACT_GAP_CYC` cycles apart. Slower transitions keep it in state 3. State 3 is never followed directly by state 2.
- R7: `idle_short` pulses high for one cycle when the first transition that ends an idle period comes fewer than `MIN_IDLE_CYC` cycles after the previous transition. It stays low when the quiet period was at least that long.
- R8: While `src_pwr_ok` is low, the channel is in state 0 (uncalibrated) within a few cycles and `tx_bit` is 1. When `src_pwr_ok` returns high, the channel enters state 1 and later state 2.
- R9: `tx_bit_oe` equals `out_en` delayed by two cycles. When it is 0, the output pin is meant to be high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_bit | input | 1 | Serial line input, asynchronous to clk |
| src_pwr_ok | input | 1 | Sending-side supply good, asynchronous |
| out_en | input | 1 | Output enable, high means drive |
| tx_bit | output | 1 | Channel output, forced high unless locked |
| tx_bit_oe | output | 1 | Output-enable qualifier for tx_bit |
| chan_state | output | 2 | 0 uncalibrated, 1 calibrating, 2 locked, 3 idle |
| idle_short | output | 1 | One-cycle pulse on a too-short idle period |

## Verification
The locked pass-through is driven with three data patterns: a one-cycle toggle, a two-cycle run and a six-cycle DC-balanced run. Together they expose a wrong pipeline latency, a dropped or repeated bit, and an idle timer that fires inside a legal run. Idle is entered with the line resting low and, in a second episode, resting high, so the output is seen being forced high from both levels. Sparse transitions are applied while idle to show that slow activity does not restart calibration, while a burst of toggles does. Quiet periods both shorter and longer than the minimum idle show that the violation flag separates the two cases. A supply drop during lock and the enable input close the set.

// File: rtl/link_chan_pkg.sv
package link_chan_pkg;
  typedef enum logic [1:0] {
    ST_UNCAL = 2'd0,
    ST_CAL   = 2'd1,
    ST_LOCK  = 2'd2,
    ST_IDLE  = 2'd3
  } chan_state_e;
endpackage

// File: rtl/lcc_rst_sync.sv
module lcc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] rs_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end

  assign rst_n_o = rs_q[1];
endmodule

// File: rtl/lcc_sync.sv
module lcc_sync #(
  parameter int          STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= RST_VAL;
        else        stg_q[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= RST_VAL;
        else        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/lcc_activity.sv
module lcc_activity #(
  parameter int IDLE_TO_CYC  = 40,
  parameter int MIN_IDLE_CYC = 1000,
  parameter int ACT_GAP_CYC  = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic edge_o,
  output logic fast_edge_o,
  output logic quiet_to_o,
  output logic short_gap_o
);
  localparam int SAT = (IDLE_TO_CYC > MIN_IDLE_CYC) ? IDLE_TO_CYC : MIN_IDLE_CYC;
  localparam int CW  = $clog2(SAT + 1);
  localparam logic [CW-1:0] SAT_V  = CW'(SAT);
  localparam logic [CW-1:0] TO_V   = CW'(IDLE_TO_CYC);
  localparam logic [CW-1:0] MIN_V  = CW'(MIN_IDLE_CYC);
  localparam logic [CW-1:0] GAP_V  = CW'(ACT_GAP_CYC);

  logic          prev_q;
  logic [CW-1:0] gap_q, gap_d;
  logic          gap_en;

  assign edge_o = line_i ^ prev_q;

  always_comb begin
    gap_en = edge_o || (gap_q != SAT_V);
    gap_d  = edge_o ? '0 : gap_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      prev_q <= line_i;
      if (gap_en) gap_q <= gap_d;
    end
  end

  assign fast_edge_o = edge_o && (gap_q < GAP_V);
  assign short_gap_o = edge_o && (gap_q < MIN_V);
  assign quiet_to_o  = (gap_q >= TO_V);
endmodule

// File: rtl/lcc_fsm.sv
module lcc_fsm
  import link_chan_pkg::*;
#(
  parameter int CAL_CYC = 50000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_ok_i,
  input  logic        edge_i,
  input  logic        fast_edge_i,
  input  logic        quiet_to_i,
  input  logic        short_gap_i,
  output chan_state_e state_o,
  output logic        viol_o
);
  localparam int CALW = (CAL_CYC > 2) ? $clog2(CAL_CYC) : 1;
  localparam logic [CALW-1:0] CAL_LAST = CALW'(CAL_CYC - 1);

  chan_state_e     st_q, st_d;
  logic [CALW-1:0] cal_q, cal_d;
  logic            armed_q, armed_d;
  logic            viol_q, viol_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_UNCAL: st_d = ST_CAL;
      ST_CAL: begin
        if (quiet_to_i)            st_d = ST_IDLE;
        else if (cal_q == CAL_LAST) st_d = ST_LOCK;
      end
      ST_LOCK: if (quiet_to_i)  st_d = ST_IDLE;
      ST_IDLE: if (fast_edge_i) st_d = ST_CAL;
      default: st_d = ST_CAL;
    endcase
    if (!pwr_ok_i) st_d = ST_UNCAL;
  end

  always_comb begin
    cal_d = (st_q == ST_CAL && st_d == ST_CAL) ? cal_q + 1'b1 : '0;
    if (st_q != ST_IDLE) armed_d = (st_d == ST_IDLE);
    else                 armed_d = armed_q && !edge_i;
    viol_d = (st_q == ST_IDLE) && armed_q && short_gap_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_CAL;
      cal_q   <= '0;
      armed_q <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cal_q   <= cal_d;
      armed_q <= armed_d;
      viol_q  <= viol_d;
    end
  end

  assign state_o = st_q;
  assign viol_o  = viol_q;
endmodule

// File: rtl/link_chan_ctrl.sv
module link_chan_ctrl
  import link_chan_pkg::*;
#(
  parameter int CAL_CYC      = 50000,
  parameter int IDLE_TO_CYC  = 40,
  parameter int MIN_IDLE_CYC = 1000,
  parameter int ACT_GAP_CYC  = 12,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_bit,
  input  logic       src_pwr_ok,
  input  logic       out_en,
  output logic       tx_bit,
  output logic       tx_bit_oe,
  output logic [1:0] chan_state,
  output logic       idle_short
);
  logic        rst_s_n;
  logic        rx_s, pwr_ok_s, en_s;
  logic        edge_w, fast_w, quiet_w, short_w;
  chan_state_e st_w;
  logic        dout_q, dout_d;

  lcc_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(rst_s_n));

  lcc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rx_sync (
    .clk(clk), .rst_n(rst_s_n), .d(rx_bit), .q(rx_s));
  lcc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pg_sync (
    .clk(clk), .rst_n(rst_s_n), .d(src_pwr_ok), .q(pwr_ok_s));
  lcc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_en_sync (
    .clk(clk), .rst_n(rst_s_n), .d(out_en), .q(en_s));

  lcc_activity #(
    .IDLE_TO_CYC(IDLE_TO_CYC), .MIN_IDLE_CYC(MIN_IDLE_CYC), .ACT_GAP_CYC(ACT_GAP_CYC)
  ) u_act (
    .clk(clk), .rst_n(rst_s_n), .line_i(rx_s),
    .edge_o(edge_w), .fast_edge_o(fast_w), .quiet_to_o(quiet_w), .short_gap_o(short_w));

  lcc_fsm #(.CAL_CYC(CAL_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_s_n), .pwr_ok_i(pwr_ok_s),
    .edge_i(edge_w), .fast_edge_i(fast_w), .quiet_to_i(quiet_w), .short_gap_i(short_w),
    .state_o(st_w), .viol_o(idle_short));

  assign dout_d = (st_w == ST_LOCK) ? rx_s : 1'b1;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) dout_q <= 1'b1;
    else          dout_q <= dout_d;
  end

  assign tx_bit     = dout_q;
  assign tx_bit_oe  = en_s;
  assign chan_state = st_w;
endmodule

// File: rtl/link_chan_ctrl_chk.sv
module link_chan_ctrl_chk
  import link_chan_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rx_bit,
  input logic       out_en,
  input logic       pg_s,
  input logic       tx_bit,
  input logic       tx_bit_oe,
  input logic [1:0] chan_state,
  input logic       idle_short
);
  // R2: output forced high outside lock
  a_r2_forced_high: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_state != ST_LOCK) |=> tx_bit);

  // R4: locked output is the input three cycles late
  a_r4_lock_follow: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(chan_state) == ST_LOCK) |-> (tx_bit == $past(rx_bit, 3)));

  // R6: idle never jumps straight to lock
  a_r6_no_idle_to_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_state == ST_IDLE) |=> (chan_state != ST_LOCK));

  // R7: violation pulse only out of idle
  a_r7_viol_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    idle_short |-> ($past(chan_state) == ST_IDLE));

  // R8: supply loss leads to uncalibrated
  a_r8_pwr_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_s |=> (chan_state == ST_UNCAL));

  // R9: enable qualifier rises only after the enable input was high
  a_r9_oe_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_bit_oe) |-> $past(out_en, 2));
endmodule

bind link_chan_ctrl link_chan_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .out_en(out_en), .pg_s(pwr_ok_s),
  .tx_bit(tx_bit), .tx_bit_oe(tx_bit_oe), .chan_state(chan_state), .idle_short(idle_short));

// File: tb/link_chan_ctrl_tb_top.sv
`timescale 1ns/1ps
module link_chan_ctrl_tb_top;
  localparam int CAL  = 200;
  localparam int ITO  = 20;
  localparam int MINI = 100;
  localparam int GAP  = 4;

  logic clk = 1'b0;
  logic rst_n, rx_bit, src_pwr_ok, out_en;
  logic tx_bit, tx_bit_oe, idle_short;
  logic [1:0] chan_state;

  always #5 clk = ~clk;

  link_chan_ctrl #(.CAL_CYC(CAL), .IDLE_TO_CYC(ITO), .MIN_IDLE_CYC(MINI), .ACT_GAP_CYC(GAP))
  dut_i (.clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .src_pwr_ok(src_pwr_ok), .out_en(out_en),
         .tx_bit(tx_bit), .tx_bit_oe(tx_bit_oe), .chan_state(chan_state), .idle_short(idle_short));

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int viol_cnt = 0;
  bit finished = 0;

  typedef struct { logic b; int c; } sb_t;
  sb_t sb_q[$];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (idle_short) viol_cnt++;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares each driven bit three cycles later (R4)
  always @(negedge clk) begin
    while (sb_q.size() > 0 && cyc >= sb_q[0].c + 3) begin
      sb_t e;
      e = sb_q.pop_front();
      n_chk++;
      if (tx_bit !== e.b) begin
        n_err++;
        $display("FAIL R4: actual %0d expected %0d", tx_bit, e.b);
      end
    end
  end

  task automatic send_bit(input logic b);
    @(posedge clk); #2;
    rx_bit = b;
    sb_q.push_back('{b, cyc});
  endtask

  // toggles rx every gap cycles, counts samples where tx_bit was not high
  task automatic toggle(input int n, input int gap, output int low_seen);
    low_seen = 0;
    for (int i = 0; i < n; i++) begin
      repeat (gap) @(posedge clk);
      #2 rx_bit = ~rx_bit;
      @(negedge clk);
      if (tx_bit !== 1'b1) low_seen++;
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    int lo;
    rst_n = 1'b0; rx_bit = 1'b0; src_pwr_ok = 1'b1; out_en = 1'b1;
    hold(4);
    check("R1 state", chan_state, 1);
    check("R1 tx", tx_bit, 1);
    check("R1 oe", tx_bit_oe, 0);
    @(posedge clk); #2 rst_n = 1'b1;
    toggle(CAL - 20, 1, lo);
    check("R2 tx high during cal", lo, 0);
    check("R3 still calibrating", chan_state, 1);
    check("R9 oe after reset", tx_bit_oe, 1);
    toggle(30, 1, lo);
    check("R3 locked", chan_state, 2);
    // R4 scoreboard patterns
    for (int i = 0; i < 40; i++) send_bit(logic'(i % 2));
    for (int i = 0; i < 40; i++) send_bit(logic'((i / 2) % 2));
    for (int i = 0; i < 48; i++) send_bit(logic'((i / 6) % 2));
    @(posedge clk); #2 rx_bit = 1'b0;
    hold(35);
    check("R5 idle low state", chan_state, 3);
    check("R5 idle low tx", tx_bit, 1);
    hold(140);
    toggle(4, 10, lo);
    check("R6 slow edges stay idle", chan_state, 3);
    check("R7 no viol long idle", viol_cnt, 0);
    toggle(4, 1, lo);
    check("R6 fast edges recalibrate", chan_state, 1);
    toggle(CAL + 10, 1, lo);
    check("R6 relock", chan_state, 2);
    // short idle, line resting high
    if (rx_bit == 1'b0) toggle(1, 1, lo);
    hold(50);
    check("R5 idle high state", chan_state, 3);
    check("R5 idle high tx", tx_bit, 1);
    toggle(4, 1, lo);
    hold(2);
    check("R7 short idle pulse", viol_cnt, 1);
    toggle(CAL + 10, 1, lo);
    check("R3 lock again", chan_state, 2);
    // supply loss
    @(posedge clk); #2 src_pwr_ok = 1'b0;
    toggle(6, 1, lo);
    check("R8 uncal state", chan_state, 0);
    toggle(20, 1, lo);
    check("R8 tx high", lo, 0);
    @(posedge clk); #2 src_pwr_ok = 1'b1;
    toggle(6, 1, lo);
    check("R8 recal", chan_state, 1);
    toggle(CAL + 10, 1, lo);
    check("R8 relock", chan_state, 2);
    // enable
    @(posedge clk); #2 out_en = 1'b0;
    hold(4);
    check("R9 oe low", tx_bit_oe, 0);
    @(posedge clk); #2 out_en = 1'b1;
    hold(4);
    check("R9 oe high", tx_bit_oe, 1);
    hold(5);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule